// File: doc/BRIEF.md
# Dual-role SPI engine with programmable select

This block moves one 8-bit word per exchange over a four-wire serial link. It plays either side of the link. As a master it produces the serial clock, the select line and the outgoing data bit. As a slave it takes clock and select from outside and drives its outgoing bit only while it is selected. A single control register sets the role, the master sub-mode, the select polarity, the output drive style, low-power gating and interrupt gating. A completion flag records each finished word and can raise an interrupt.

The select line has two master sub-modes. In interval mode the engine pulses the line for the length of each exchange. In manual mode the line follows a register bit through the polarity setting. Open-drain drive is modelled by a separate data/enable pair per pin, and the enable is active only while the pin is pulled low. When low-power gating is armed and the system doze input is high, the engine freezes in place and resumes where it stopped once doze is released.

The controller is one state machine with six states:
- `ST_IDLE`: waits.
- `ST_LOW` and `ST_HIGH`: the two half-bits of a master bit, with the clock low and then high.
- `ST_FINISH`: a master tail cycle that holds select and latches the received word.
- `ST_SLV_SEL`: a selected slave shifting on clock rises.
- `ST_SLV_HOLD`: a slave that has received a full word and waits for deselect.

The transitions are:
- IDLE→LOW: start while master with transfers enabled.
- LOW→HIGH: always.
- HIGH→LOW: bits remain.
- HIGH→FINISH: the last bit.
- FINISH→IDLE: always.
- IDLE→SLV_SEL: select goes low in slave role.
- SLV_SEL→SLV_HOLD: the eighth clock rise.
- SLV_SEL or SLV_HOLD→IDLE: select goes high.
- Any state: holds while frozen.

Top module: `spi_dual_role`

## Requirements
- R1: Control bit 0 selects the role, with 1 for master and 0 for slave. In the slave role `sclk_oe` and `cs_oe` stay 0. In the master role both pins are driven as set by R6.
- R2: Control bit 2 gates master transfers. While it is 0, `start` is ignored, no clock edge appears and `done` stays 0.
- R3: Control bit 1 picks the master sub-mode. When it is 1 (interval), the select line is asserted only from the first clock half-bit through the tail cycle, and it is negated in idle. When it is 0 (manual), the select line reflects control bit 2 whether or not an exchange is running.
- R4: Control bit 3 sets the polarity of the select output. With 0 the asserted level is 0, and with 1 the asserted level is 1.
- R5: In the slave role, `sel_n_in` low selects the engine. Clock rises are ignored while it is high. Control bit 2 has no effect, and `ctl_rdata` returns the written value, not the pin level.
- R6: Control bit 4 set in the master role makes clock, select and data open-drain: each enable is 1 only while its value is 0. The bit has no effect in the slave role, where the data output is driven whenever the engine is selected.
- R7: When control bit 5 is 1 and `sys_doze` is 1, the engine freezes. State, shift count and pin values hold, and the exchange resumes and completes correctly after release. With bit 5 at 0, `sys_doze` has no effect.
- R8: `irq` equals `done` AND control bit 6. After reset the control register reads 0, and `done` and `irq` are 0.
- R9: A master exchange shifts 8 bits MSB first with the clock idle low. Data is sampled on the clock rise. `done` rises exactly 17 clock cycles after the edge that accepts `start`, and `rx_data` holds the received word.
- R10: `done_clr` clears `done`. A completion in the same cycle as `done_clr` wins, so `done` ends up 1.
- R11: A slave exchange returns the 8 bits sampled on the 8 clock rises in `rx_data`. It presents `tx_data` MSB first on `sdo_o` and sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register write value |
| ctl_rdata | output | 7 | Control register contents |
| start | input | 1 | Master exchange request |
| tx_data | input | 8 | Word to send |
| rx_data | output | 8 | Last word received |
| done | output | 1 | Completion flag |
| done_clr | input | 1 | Completion flag clear strobe |
| irq | output | 1 | Interrupt request |
| sys_doze | input | 1 | System low-power request |
| sclk_in | input | 1 | Serial clock input (slave role) |
| sel_n_in | input | 1 | Select input, active low (slave role) |
| sdi | input | 1 | Serial data input |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock output enable |
| cs_o | output | 1 | Select value |
| cs_oe | output | 1 | Select output enable |
| sdo_o | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
A finishing exchange sets the completion flag in the same cycle in which software may pulse the clear strobe. The bench starts an exchange and counts the cycles out to the tail cycle. It then raises `done_clr` so that the clear is sampled on the very edge that records completion, and it expects `done` and `irq` to stay high afterwards. A second collision puts doze in the middle of a shift. The bench checks that the clock line and the flag hold, and that the word still arrives intact.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
    localparam int CTL_W = 7;

    // bit 0 is master, bit 6 is irq_on
    typedef struct packed {
        logic irq_on;
        logic doze_off;
        logic open_drain;
        logic sense;
        logic enable;
        logic interval;
        logic master;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FINISH,
        ST_SLV_SEL,
        ST_SLV_HOLD
    } state_t;
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_dr_regs.sv
module spi_dr_regs
    import spi_dr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             done_set,
    input  logic             done_clr,
    output ctl_t             ctl,
    output logic             done,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl  <= '0;
            done <= 1'b0;
        end else begin
            if (ctl_we) ctl <= ctl_t'(ctl_wdata);
            // completion outranks a clear in the same cycle
            if (done_set)      done <= 1'b1;
            else if (done_clr) done <= 1'b0;
        end
    end

    assign irq = done & ctl.irq_on;
endmodule

// File: rtl/spi_dr_fsm.sv
module spi_dr_fsm
    import spi_dr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              xfer_enable,
    input  logic              frozen,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sdi,
    input  logic              sclk_in,
    input  logic              sel_n_in,
    output state_t            state,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_set,
    output logic              sclk_v,
    output logic              sdo_v,
    output logic              busy,
    output logic              slv_sel
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    state_t            nxt;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              s_sclk, s_sel_n, s_sdi, sclk_q, rise;

    spi_dr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, sel_n_in, sdi}),
        .q     ({s_sclk, s_sel_n, s_sdi})
    );

    assign rise = s_sclk & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!frozen) begin
            unique case (state)
                ST_IDLE: begin
                    if (mode_master) begin
                        if (start && xfer_enable) nxt = ST_LOW;
                    end else if (!s_sel_n) begin
                        nxt = ST_SLV_SEL;
                    end
                end
                ST_LOW:      nxt = ST_HIGH;
                ST_HIGH:     nxt = (cnt == LAST) ? ST_FINISH : ST_LOW;
                ST_FINISH:   nxt = ST_IDLE;
                ST_SLV_SEL: begin
                    if (s_sel_n)                   nxt = ST_IDLE;
                    else if (rise && cnt == LAST)  nxt = ST_SLV_HOLD;
                end
                ST_SLV_HOLD: if (s_sel_n) nxt = ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            rx_data <= '0;
            sclk_q  <= 1'b0;
        end else begin
            sclk_q <= s_sclk;
            if (!frozen) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (nxt == ST_LOW || nxt == ST_SLV_SEL) sh <= tx_data;
                    end
                    ST_HIGH: begin
                        sh  <= {sh[DATA_W-2:0], sdi};
                        cnt <= cnt + 1'b1;
                    end
                    ST_FINISH: rx_data <= sh;
                    ST_SLV_SEL: begin
                        if (!s_sel_n && rise) begin
                            sh  <= {sh[DATA_W-2:0], s_sdi};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST) rx_data <= {sh[DATA_W-2:0], s_sdi};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sclk_v   = (state == ST_HIGH);
        sdo_v    = sh[DATA_W-1];
        busy     = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_FINISH);
        slv_sel  = (state == ST_SLV_SEL) || (state == ST_SLV_HOLD);
        done_set = !frozen && ((state == ST_FINISH) ||
                   (state == ST_SLV_SEL && !s_sel_n && rise && cnt == LAST));
    end
endmodule

// File: rtl/spi_dr_pad.sv
module spi_dr_pad #(
    parameter int N = 3
) (
    input  logic [N-1:0] val,
    input  logic [N-1:0] drive,
    input  logic         od,
    output logic [N-1:0] pin_o,
    output logic [N-1:0] pin_oe
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        assign pin_oe[g] = drive[g] & (od ? ~val[g] : 1'b1);
        assign pin_o[g]  = od ? 1'b0 : val[g];
    end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
    import spi_dr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    input  logic              done_clr,
    output logic              irq,
    input  logic              sys_doze,
    input  logic              sclk_in,
    input  logic              sel_n_in,
    input  logic              sdi,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              cs_o,
    output logic              cs_oe,
    output logic              sdo_o,
    output logic              sdo_oe
);
    localparam int NPIN = 3;

    ctl_t            ctl;
    state_t          state;
    logic            frozen, done_set, busy, slv_sel, sclk_v, sdo_v, cs_act, cs_v;
    logic [NPIN-1:0] pad_val, pad_drv, pad_o, pad_oe;

    spi_dr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .done_set  (done_set),
        .done_clr  (done_clr),
        .ctl       (ctl),
        .done      (done),
        .irq       (irq)
    );

    assign ctl_rdata = ctl;
    assign frozen    = ctl.doze_off & sys_doze;

    spi_dr_fsm #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_master (ctl.master),
        .xfer_enable (ctl.enable),
        .frozen      (frozen),
        .start       (start),
        .tx_data     (tx_data),
        .sdi         (sdi),
        .sclk_in     (sclk_in),
        .sel_n_in    (sel_n_in),
        .state       (state),
        .rx_data     (rx_data),
        .done_set    (done_set),
        .sclk_v      (sclk_v),
        .sdo_v       (sdo_v),
        .busy        (busy),
        .slv_sel     (slv_sel)
    );

    // select path: sub-mode picks the source, sense picks the level
    assign cs_act = ctl.interval ? busy : ctl.enable;
    assign cs_v   = ctl.sense ? cs_act : ~cs_act;

    assign pad_val = {cs_v, sclk_v, sdo_v};
    assign pad_drv = {ctl.master, ctl.master, ctl.master | slv_sel};

    spi_dr_pad #(.N(NPIN)) u_pad (
        .val    (pad_val),
        .drive  (pad_drv),
        .od     (ctl.master & ctl.open_drain),
        .pin_o  (pad_o),
        .pin_oe (pad_oe)
    );

    assign {cs_o, sclk_o, sdo_o}    = pad_o;
    assign {cs_oe, sclk_oe, sdo_oe} = pad_oe;
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk
    import spi_dr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             ctl_we,
    input logic             sys_doze,
    input state_t           state,
    input logic             sclk_o,
    input logic             sclk_oe,
    input logic             cs_o,
    input logic             cs_oe,
    input logic             done,
    input logic             irq
);
    logic cs_line;
    assign cs_line = cs_oe ? cs_o : 1'b1;

    a_r1_slave_released: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> (!sclk_oe && !cs_oe));

    a_r2_no_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ctl_rdata[0] && !ctl_rdata[2]) |=> (state != ST_LOW));

    a_r3_interval_idle_negated: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && ctl_rdata[1] && state == ST_IDLE) |-> (cs_line == !ctl_rdata[3]));

    a_r6_od_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && ctl_rdata[4] && state == ST_HIGH) |-> !sclk_oe);

    a_r7_doze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[5] && sys_doze && !ctl_we) |=> ($stable(state) && $stable(sclk_o)));

    a_r10_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !(ctl_rdata[5] && sys_doze)) |=> done);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[6] |-> !irq);
endmodule

bind spi_dual_role spi_dual_role_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .ctl_we    (ctl_we),
    .sys_doze  (sys_doze),
    .state     (state),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .cs_o      (cs_o),
    .cs_oe     (cs_oe),
    .done      (done),
    .irq       (irq)
);

// File: tb/spi_dual_role_tb.sv
module spi_dual_role_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 6;
    // {cfg[6:0], tx[7:0]}; cfg bits: 6 irq, 5 doze, 4 od, 3 sense, 2 en, 1 interval, 0 master
    localparam logic [14:0] VEC [NVEC] = '{
        {7'b1000111, 8'hA5},
        {7'b0001111, 8'h3C},
        {7'b1010111, 8'h81},
        {7'b0011101, 8'h7E},
        {7'b1000101, 8'h00},
        {7'b0001111, 8'hFF}
    };

    logic       clk = 0, rst_n = 0;
    logic       ctl_we = 0, start = 0, done_clr = 0, sys_doze = 0;
    logic [6:0] ctl_wdata = '0;
    logic [6:0] ctl_rdata;
    logic [7:0] tx_data = '0, rx_data;
    logic       done, irq;
    logic       sclk_in = 0, sel_n_in = 1, sdi;
    logic       sclk_o, sclk_oe, cs_o, cs_oe, sdo_o, sdo_oe;
    logic       tb_slave = 0, slv_sdi = 0;
    logic       line_sclk, line_cs, line_sdo;

    int n_chk = 0, n_bad = 0;
    logic       finished = 0;
    logic [6:0] cfg;
    logic [7:0] txv, got, sent;
    logic       exp_lvl, held, oe_ok;

    assign line_sclk = sclk_oe ? sclk_o : 1'b1;
    assign line_cs   = cs_oe   ? cs_o   : 1'b1;
    assign line_sdo  = sdo_oe  ? sdo_o  : 1'b1;
    assign sdi       = tb_slave ? slv_sdi : line_sdo;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dual_role u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .start(start), .tx_data(tx_data), .rx_data(rx_data),
        .done(done), .done_clr(done_clr), .irq(irq), .sys_doze(sys_doze),
        .sclk_in(sclk_in), .sel_n_in(sel_n_in), .sdi(sdi),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .cs_o(cs_o), .cs_oe(cs_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [6:0] v);
        ctl_wdata = v; ctl_we = 1;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic clr_done();
        done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    // returns between accepting edge k and k+1
    task automatic kick(input logic [7:0] v);
        tx_data = v; start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 R1 reset state
        chk("R8 ctl reset", ctl_rdata, 0);
        chk("R8 done reset", done, 0);
        chk("R8 irq reset", irq, 0);
        chk("R1 sclk_oe reset", sclk_oe, 0);
        chk("R1 cs_oe reset", cs_oe, 0);
        rst_n = 1;
        @(negedge clk);

        // vector table: master loopback
        for (int i = 0; i < NVEC; i++) begin
            cfg = VEC[i][14:8]; txv = VEC[i][7:0];
            wr_cfg(cfg);
            clr_done();
            kick(txv);
            repeat (2) @(negedge clk);
            chk("R3 R4 cs asserted mid-exchange", line_cs, cfg[3]);
            chk("R1 master drives sclk", sclk_oe | (cfg[4] & ~sclk_o), 1);
            repeat (16) @(negedge clk);
            chk("R9 loopback word", rx_data, txv);
            chk("R8 irq follows gate", irq, cfg[6]);
            exp_lvl = cfg[1] ? ~cfg[3] : cfg[3];
            chk("R3 cs idle level", line_cs, exp_lvl);
            chk("R9 clock idle low", line_sclk, 0);
        end

        // R2 enable bit gates start
        wr_cfg(7'b0000011);
        clr_done();
        kick(8'h55);
        repeat (25) begin
            @(negedge clk);
            if (line_sclk !== 1'b0) chk("R2 no clock when disabled", line_sclk, 0);
        end
        chk("R2 no done when disabled", done, 0);

        // R3 manual with enable 0: negated at sense 1
        wr_cfg(7'b0001001);
        @(negedge clk);
        chk("R3 manual follows enable bit", line_cs, 0);

        // R9 MSB-first order and exact timing
        wr_cfg(7'b0000111);
        clr_done();
        kick(8'hC1);
        got = '0;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            got[7-b] = line_sdo;
            if (line_sclk !== 1'b1) chk("R9 clock high in sample half", line_sclk, 1);
            @(negedge clk);
        end
        chk("R9 MSB first bits", got, 8'hC1);
        chk("R9 done not yet", done, 0);
        @(negedge clk);
        chk("R9 done on time", done, 1);

        // R10 completion collides with clear
        wr_cfg(7'b1000111);
        clr_done();
        kick(8'h69);
        repeat (16) @(negedge clk);
        done_clr = 1;
        @(negedge clk); done_clr = 0;
        chk("R10 set wins over clear", done, 1);
        chk("R10 irq after collision", irq, 1);
        chk("R10 word intact", rx_data, 8'h69);
        clr_done();
        chk("R10 clear alone", done, 0);
        chk("R8 irq drops with done", irq, 0);

        // R7 doze freezes mid-exchange then resumes
        wr_cfg(7'b0100111);
        kick(8'h5A);
        repeat (4) @(negedge clk);
        sys_doze = 1;
        @(negedge clk);
        held = line_sclk;
        repeat (8) @(negedge clk);
        chk("R7 clock held in doze", line_sclk, held);
        chk("R7 no done in doze", done, 0);
        sys_doze = 0;
        repeat (25) @(negedge clk);
        chk("R7 resumed done", done, 1);
        chk("R7 resumed word", rx_data, 8'h5A);

        // R7 doze without gate bit has no effect
        wr_cfg(7'b0000111);
        clr_done();
        sys_doze = 1;
        kick(8'h33);
        repeat (16) @(negedge clk);
        chk("R7 ungated doze early", done, 0);
        @(negedge clk);
        chk("R7 ungated doze on time", done, 1);
        chk("R7 ungated doze word", rx_data, 8'h33);
        sys_doze = 0;

        // slave role: od set and enable set, both must be ignored
        tb_slave = 1;
        wr_cfg(7'b0011100);
        clr_done();
        chk("R6 slave ignores od sclk", sclk_oe, 0);
        chk("R1 slave cs released", cs_oe, 0);
        // R5 clocks without select are ignored
        repeat (8) begin
            sclk_in = 1; repeat (4) @(negedge clk);
            sclk_in = 0; repeat (4) @(negedge clk);
        end
        chk("R5 unselected clocks ignored", done, 0);
        tx_data = 8'h96; sent = 8'h4B; got = '0; oe_ok = 1;
        sel_n_in = 0;
        repeat (6) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            slv_sdi = sent[7-b];
            repeat (2) @(negedge clk);
            got[7-b] = sdo_o;
            if (!sdo_oe) oe_ok = 0;
            sclk_in = 1; repeat (4) @(negedge clk);
            sclk_in = 0; repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R11 slave received word", rx_data, 8'h4B);
        chk("R11 slave sent MSB first", got, 8'h96);
        chk("R11 slave done", done, 1);
        chk("R6 slave data driven totem-pole", oe_ok, 1);
        chk("R5 enable readback unchanged", ctl_rdata, 7'b0011100);
        sel_n_in = 1;
        repeat (6) @(negedge clk);
        tb_slave = 0;

        finished = 1;
        finish_run();
    end
endmodule